// File: doc/BRIEF.md
# SPI Pass-Through Routing Controller

This block is an SPI target with a small register file. The register file holds the normal configuration of four general-purpose I/O pins, edge flags with interrupt masks, and a routing register. A completed write to the routing register arms a pass-through state, which starts when chip select is released. While it lasts, the block's own serial lines reach the I/O pins, so a host can talk to a downstream SPI device through this block.

During pass-through, pin 4 (gpio index 3) carries the inverted chip select as the downstream select. Pin 3 (index 2) carries SCLK and pin 2 (index 1) carries MOSI. The level on pin 1 (index 0) is returned on MISO. Pulling chip select low again ends pass-through at once, and that frame is then handled as an ordinary register access. Edge detection on the pins keeps running the whole time.

Top module: `spi_passthru_router`

## Requirements
- R1: After reset every pin control register is 0 (input mode: gpio_oe and gpio_out low), the routing register reads 0, irq is low and miso_oe is low.
- R2: A register access is a 16-bit SPI mode 0 frame, MSB first: a header byte and then a data byte. In the header, bit 7 = 0 means write and bits 6:0 are the address. Addresses 0 to 3 are pin control, 4 is routing, 5 is edge flags and 6 is interrupt mask. A write takes effect on the 16th SCLK rising edge.
- R3: A frame whose chip select rises before the 16th SCLK rising edge changes no register and does not arm pass-through.
- R4: A pin control byte holds mode in bits 1:0 and level in bit 2. Mode 00 is input, 01 drives the level, 10 is open-drain (drives 0 only when level is 0), and 11 is high impedance.
- R5: A header with bit 7 = 1 is a read. The addressed register comes out on miso MSB first during the data byte, changing on SCLK falling edges, with miso_oe high while chip select is low.
- R6: Routing register bits 7, 6, 5 and 4 enable pins 4, 3, 2 and 1 (gpio index 3 to 0), and bits 3:0 are ignored. Pass-through becomes active only when chip select rises at the end of a complete write to the routing register. It then stays active while chip select stays high.
- R7: Pass-through ends in the same instant that chip select goes low. It does not resume until another complete write to the routing register.
- R8: While active, an enabled pin 4 drives the inverted chip select (low), an enabled pin 3 drives SCLK and an enabled pin 2 drives MOSI, all with their output enables high.
- R9: While active with pin 1 enabled, miso follows gpio_in[0] with miso_oe high. Outside register reads and that case, miso_oe is low.
- R10: A pin whose enable bit is clear keeps its normal configured state during pass-through.
- R11: Flag register bits 3:0 latch rising edges and bits 7:4 latch falling edges of gpio_in[3:0]. Flags are sticky and are cleared by writing 1. The mask register uses the same layout. irq is the OR of flags that are masked in. Edge detection continues during pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from host |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| miso_oe | output | 1 | Output enable for miso |
| gpio_in | input | NPIN | Pin input levels |
| gpio_out | output | NPIN | Pin output levels |
| gpio_oe | output | NPIN | Pin output enables |
| irq | output | 1 | Masked edge interrupt |

## Verification
The bench holds chip select low after a complete routing write and checks that the pins still show their normal state. A design that armed on the 16th bit would already route here. It drops chip select for one instant and checks that the routing is gone before any clock edge, then checks it does not return while chip select sits high again; a design using only a synchronized select would lag here, and one that forgets to clear the armed state would reactivate. Truncated frames must leave the registers and the routing untouched, and a routing byte with only its low nibble set must route nothing. Edge flags are toggled during pass-through, then cleared one bit at a time, which catches a design that freezes detection while routing or clears more than it was told.

// File: rtl/spi_pt_pkg.sv
package spi_pt_pkg;
  localparam int NPIN_DEF = 4;
  localparam int DW       = 8;
  localparam int ADDR_W   = DW - 1;

  typedef enum logic [1:0] {
    PM_IN     = 2'b00,
    PM_PUSH   = 2'b01,
    PM_ODRAIN = 2'b10,
    PM_HIZ    = 2'b11
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_ROUTE = 7'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 7'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 7'd6;

  // routing roles by pin index
  localparam int PIN_RET = 0;
  localparam int PIN_DAT = 1;
  localparam int PIN_CLK = 2;
  localparam int PIN_SEL = 3;
endpackage

// File: rtl/spi_pt_frontend.sv
module spi_pt_frontend
  import spi_pt_pkg::*;
#(
  parameter int W = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              sel_o,
  output logic              csn_rise_o,
  output logic              wr_stb_o,
  output logic [W-2:0]      wr_addr_o,
  output logic [W-1:0]      wr_data_o,
  output logic              rd_req_o,
  output logic [W-2:0]      rd_addr_o,
  input  logic [W-1:0]      rd_data_i,
  output logic              miso_bit_o,
  output logic              miso_drv_o
);
  localparam int FW = 2 * W;
  localparam int CW = $clog2(FW + 1);

  logic [1:0] csn_q, sclk_q, mosi_q;
  logic       csn_d, sclk_d;
  logic       csn_s, sclk_s, mosi_s, rise, fall;
  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;
  logic [W-1:0]  hdr, obuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_q  <= '1;
      csn_d  <= 1'b1;
      sclk_q <= '0;
      sclk_d <= 1'b0;
      mosi_q <= '0;
    end else begin
      csn_q  <= {csn_q[0], csn};
      sclk_q <= {sclk_q[0], sclk};
      mosi_q <= {mosi_q[0], mosi};
      csn_d  <= csn_s;
      sclk_d <= sclk_s;
    end
  end

  assign csn_s  = csn_q[1];
  assign sclk_s = sclk_q[1];
  assign mosi_s = mosi_q[1];
  assign rise   = sclk_s & ~sclk_d & ~csn_s;
  assign fall   = ~sclk_s & sclk_d & ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      hdr  <= '0;
      obuf <= '0;
    end else if (csn_s) begin
      cnt <= '0;
    end else begin
      if (rise) begin
        if (cnt != CW'(FW)) cnt <= cnt + 1'b1;
        sh <= {sh[W-3:0], mosi_s};
        if (cnt == CW'(W-1)) hdr <= {sh, mosi_s};
      end
      if (rd_req_o)
        obuf <= rd_data_i;
      else if (fall && cnt > CW'(W))
        obuf <= {obuf[W-2:0], 1'b0};
    end
  end

  assign sel_o      = ~csn_s;
  assign csn_rise_o = csn_s & ~csn_d;
  assign rd_req_o   = rise && (cnt == CW'(W-1)) && sh[W-2];
  assign rd_addr_o  = {sh[W-3:0], mosi_s};
  assign wr_stb_o   = rise && (cnt == CW'(FW-1)) && !hdr[W-1];
  assign wr_addr_o  = hdr[W-2:0];
  assign wr_data_o  = {sh, mosi_s};
  assign miso_bit_o = obuf[W-1];
  assign miso_drv_o = ~csn_s && hdr[W-1] && (cnt >= CW'(W));
endmodule

// File: rtl/spi_pt_regs.sv
module spi_pt_regs
  import spi_pt_pkg::*;
#(
  parameter int NPIN = NPIN_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DW-1:0]          rd_data_o,
  input  logic                   sel_i,
  input  logic                   csn_rise_i,
  input  logic [2*NPIN-1:0]      flags_i,
  output logic [2*NPIN-1:0]      flag_clr_o,
  output logic [2*NPIN-1:0]      mask_o,
  output logic [NPIN-1:0][1:0]   mode_o,
  output logic [NPIN-1:0]        level_o,
  output logic [NPIN-1:0]        route_en_o,
  output logic                   armed_o
);
  localparam int PW = $clog2(NPIN);

  logic [DW-1:0] ctrl [NPIN];
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPIN; k++) ctrl[k] <= '0;
      route_en_o <= '0;
      mask_o     <= '0;
    end else if (wr_stb_i) begin
      if (wr_addr_i < ADDR_W'(NPIN)) ctrl[wr_addr_i[PW-1:0]] <= wr_data_i;
      if (wr_addr_i == A_ROUTE) route_en_o <= wr_data_i[DW-1 -: NPIN];
      if (wr_addr_i == A_MASK)  mask_o     <= wr_data_i[2*NPIN-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      if (wr_stb_i && wr_addr_i == A_ROUTE) pend <= 1'b1;
      else if (csn_rise_i)                  pend <= 1'b0;
      if (sel_i)           armed_o <= 1'b0;
      else if (csn_rise_i) armed_o <= pend;
    end
  end

  assign flag_clr_o = (wr_stb_i && wr_addr_i == A_FLAG) ? wr_data_i[2*NPIN-1:0] : '0;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NPIN)) rd_data_o = ctrl[rd_addr_i[PW-1:0]];
    else if (rd_addr_i == A_ROUTE) rd_data_o = {route_en_o, {(DW-NPIN){1'b0}}};
    else if (rd_addr_i == A_FLAG)  rd_data_o = DW'(flags_i);
    else if (rd_addr_i == A_MASK)  rd_data_o = DW'(mask_o);
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_cfg
    assign mode_o[i]  = ctrl[i][1:0];
    assign level_o[i] = ctrl[i][2];
  end

  // R6: arming only follows a chip-select release
  a_r6_arm_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_o) |-> $past(csn_rise_i));
  // R7: a selected frame always drops the armed state
  a_r7_drop_on_select: assert property (@(posedge clk) disable iff (rst)
    sel_i |=> !armed_o);
endmodule

// File: rtl/spi_pt_edges.sv
module spi_pt_edges #(
  parameter int NPIN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPIN-1:0]     pin_i,
  input  logic [2*NPIN-1:0]   clr_i,
  input  logic [2*NPIN-1:0]   mask_i,
  output logic [2*NPIN-1:0]   flags_o,
  output logic                irq_o
);
  logic [NPIN-1:0]   q1, q2, prev;
  logic [2*NPIN-1:0] setv;

  assign setv = {~q2 & prev, q2 & ~prev};

  always_ff @(posedge clk) begin
    if (rst) begin
      q1      <= '0;
      q2      <= '0;
      prev    <= '0;
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      q1      <= pin_i;
      q2      <= q1;
      prev    <= q2;
      flags_o <= (flags_o & ~clr_i) | setv;
      irq_o   <= |(flags_o & mask_i);
    end
  end

  // R11: write-one-to-clear removes the flag unless a new edge arrives
  a_r11_w1c: assert property (@(posedge clk) disable iff (rst)
    (|clr_i) |=> ((flags_o & $past(clr_i) & ~$past(setv)) == '0));
endmodule

// File: rtl/spi_pt_pinmux.sv
module spi_pt_pinmux
  import spi_pt_pkg::*;
#(
  parameter int NPIN = NPIN_DEF
) (
  input  logic [NPIN-1:0][1:0] mode_i,
  input  logic [NPIN-1:0]      level_i,
  input  logic [NPIN-1:0]      route_i,
  input  logic                 sclk_i,
  input  logic                 mosi_i,
  input  logic                 csn_i,
  output logic [NPIN-1:0]      out_o,
  output logic [NPIN-1:0]      oe_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic n_out, n_oe;
    always_comb begin
      unique case (pin_mode_e'(mode_i[i]))
        PM_PUSH:   begin n_out = level_i[i]; n_oe = 1'b1;        end
        PM_ODRAIN: begin n_out = 1'b0;       n_oe = ~level_i[i]; end
        default:   begin n_out = 1'b0;       n_oe = 1'b0;        end
      endcase
    end
    if (i == PIN_SEL) begin : g_sel
      assign out_o[i] = route_i[i] ? ~csn_i : n_out;
      assign oe_o[i]  = route_i[i] | n_oe;
    end else if (i == PIN_CLK) begin : g_clk
      assign out_o[i] = route_i[i] ? sclk_i : n_out;
      assign oe_o[i]  = route_i[i] | n_oe;
    end else if (i == PIN_DAT) begin : g_dat
      assign out_o[i] = route_i[i] ? mosi_i : n_out;
      assign oe_o[i]  = route_i[i] | n_oe;
    end else if (i == PIN_RET) begin : g_ret
      assign out_o[i] = route_i[i] ? 1'b0 : n_out;
      assign oe_o[i]  = route_i[i] ? 1'b0 : n_oe;
    end else begin : g_plain
      assign out_o[i] = n_out;
      assign oe_o[i]  = n_oe;
    end
  end
endmodule

// File: rtl/spi_passthru_router.sv
module spi_passthru_router
  import spi_pt_pkg::*;
#(
  parameter int NPIN = NPIN_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            csn,
  input  logic            mosi,
  output logic            miso,
  output logic            miso_oe,
  input  logic [NPIN-1:0] gpio_in,
  output logic [NPIN-1:0] gpio_out,
  output logic [NPIN-1:0] gpio_oe,
  output logic            irq
);
  logic                 sel, csn_rise, wr_stb, rd_req, miso_bit, miso_drv, armed, pt_act;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [DW-1:0]        wr_data, rd_data;
  logic [2*NPIN-1:0]    flags, flag_clr, mask;
  logic [NPIN-1:0][1:0] mode;
  logic [NPIN-1:0]      level, route_en, route;

  spi_pt_frontend #(.W(DW)) u_fe (
    .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .mosi(mosi),
    .sel_o(sel), .csn_rise_o(csn_rise),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .miso_bit_o(miso_bit), .miso_drv_o(miso_drv)
  );

  spi_pt_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sel_i(sel), .csn_rise_i(csn_rise), .flags_i(flags),
    .flag_clr_o(flag_clr), .mask_o(mask), .mode_o(mode),
    .level_o(level), .route_en_o(route_en), .armed_o(armed)
  );

  spi_pt_edges #(.NPIN(NPIN)) u_edges (
    .clk(clk), .rst(rst), .pin_i(gpio_in), .clr_i(flag_clr),
    .mask_i(mask), .flags_o(flags), .irq_o(irq)
  );

  // raw chip select ends pass-through without waiting for a clock
  assign pt_act = armed & csn;
  assign route  = route_en & {NPIN{pt_act}};

  spi_pt_pinmux #(.NPIN(NPIN)) u_mux (
    .mode_i(mode), .level_i(level), .route_i(route),
    .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .out_o(gpio_out), .oe_o(gpio_oe)
  );

  assign miso    = route[PIN_RET] ? gpio_in[PIN_RET] : miso_bit;
  assign miso_oe = route[PIN_RET] | (~csn & miso_drv);

  // R8: enabled downstream select is driven low while routing
  a_r8_sel_low: assert property (@(posedge clk) disable iff (rst)
    (pt_act && route_en[PIN_SEL]) |-> (!gpio_out[PIN_SEL] && gpio_oe[PIN_SEL]));
  // R9: returned data follows pin 1 during routing
  a_r9_miso_follow: assert property (@(posedge clk) disable iff (rst)
    (pt_act && route_en[PIN_RET]) |-> (miso_oe && miso == gpio_in[PIN_RET]));
  // R9: no drive on miso while deselected outside routing
  a_r9_miso_idle: assert property (@(posedge clk) disable iff (rst)
    (!pt_act && csn) |-> !miso_oe);
endmodule

// File: tb/spi_passthru_router_tb.sv
module spi_passthru_router_tb;
  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [3:0] gpio_in = '0;
  logic       miso, miso_oe, irq;
  logic [3:0] gpio_out, gpio_oe;
  logic [7:0] rv;
  int n_chk = 0, n_fail = 0;

  localparam int H = 6;
  // {addr, data, expected gpio_out, expected gpio_oe}
  localparam logic [23:0] VEC [8] = '{
    24'h00_05_1_1, 24'h01_01_1_3, 24'h02_02_1_7, 24'h03_06_1_7,
    24'h03_03_1_7, 24'h02_06_1_3, 24'h00_00_0_2, 24'h03_05_8_A
  };

  always #2 clk = ~clk;

  spi_passthru_router u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                      input bit hold, output logic [7:0] r);
    logic [15:0] f;
    f = {a, d};
    r = '0;
    csn = 1'b0;
    waitc(H);
    for (int b = 0; b < nbits; b++) begin
      mosi = f[15-b];
      waitc(H);
      if (b >= 8) r = {r[6:0], miso};
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
    end
    mosi = 1'b0;
    waitc(H);
    if (!hold) begin
      csn = 1'b1;
      waitc(12);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(a, d, 16, 1'b0, r);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] r);
    xfer(a | 8'h80, 8'h00, 16, 1'b0, r);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    waitc(5);
    rst = 1'b0;
    waitc(2);
    chk("R1 pins", {gpio_out, gpio_oe}, 8'h00);
    chk("R1 miso_oe/irq", {miso_oe, irq}, 2'b00);
    rd(8'h04, rv);
    chk("R1 route reg", rv, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      chk("R2 R4 pin config", {gpio_out, gpio_oe}, VEC[i][7:0]);
    end

    rd(8'h03, rv);
    chk("R5 read ctrl3", rv, 8'h05);
    rd(8'h01, rv);
    chk("R5 read ctrl1", rv, 8'h01);
    chk("R9 miso idle", miso_oe, 1'b0);

    // truncated frames
    xfer(8'h03, 8'h00, 12, 1'b0, rv);
    chk("R3 short write", {gpio_out, gpio_oe}, 8'h8A);
    xfer(8'h04, 8'hF0, 15, 1'b0, rv);
    sclk = 1'b1; #1;
    chk("R3 short route write", {gpio_out, gpio_oe}, 8'h8A);
    sclk = 1'b0; #1;

    wr(8'h06, 8'h11);

    // routing write held selected: not yet active
    xfer(8'h04, 8'hF0, 16, 1'b1, rv);
    chk("R6 inactive before release", {gpio_out, gpio_oe}, 8'h8A);
    csn = 1'b1;
    waitc(8);
    chk("R6 R8 active", {gpio_out, gpio_oe}, 8'h0E);
    sclk = 1'b1; #1;
    chk("R8 sclk routed", gpio_out[2], 1'b1);
    mosi = 1'b1; #1;
    chk("R8 mosi routed", gpio_out[1], 1'b1);
    gpio_in[0] = 1'b1; #1;
    chk("R9 miso follows high", {miso_oe, miso}, 2'b11);
    sclk = 1'b0; mosi = 1'b0;
    waitc(10);
    gpio_in[0] = 1'b0; #1;
    chk("R9 miso follows low", {miso_oe, miso}, 2'b10);
    waitc(10);
    chk("R6 stays active", {gpio_out[3], gpio_oe[3]}, 2'b01);
    chk("R11 irq during routing", irq, 1'b1);

    csn = 1'b0; #1;
    chk("R7 immediate end", {gpio_out, gpio_oe}, 8'h8A);
    waitc(4);
    csn = 1'b1;
    waitc(10);
    chk("R7 no resume", {gpio_out, gpio_oe}, 8'h8A);

    rd(8'h05, rv);
    chk("R11 flags", rv, 8'h11);
    wr(8'h05, 8'h01);
    rd(8'h05, rv);
    chk("R11 clear one", rv, 8'h10);
    chk("R11 irq held by fall flag", irq, 1'b1);
    wr(8'h05, 8'h10);
    chk("R11 irq cleared", irq, 1'b0);
    gpio_in[1] = 1'b1;
    waitc(8);
    chk("R11 masked-out edge", irq, 1'b0);
    rd(8'h05, rv);
    chk("R11 unmasked flag", rv, 8'h02);

    wr(8'h04, 8'h4F);
    sclk = 1'b1; #1;
    chk("R10 partial routing", {gpio_out, gpio_oe}, 8'hCE);
    chk("R9 miso not routed", miso_oe, 1'b0);
    sclk = 1'b0; #1;

    wr(8'h04, 8'h0F);
    sclk = 1'b1; #1;
    chk("R6 low nibble ignored", {gpio_out, gpio_oe}, 8'h8A);
    sclk = 1'b0;
    rd(8'h04, rv);
    chk("R6 route readback", rv, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule